// File: doc/BRIEF.md
# Segmented Operand Memory Controller

This block is the operand store of a wide modular-arithmetic engine. It keeps four working operands and one modulus. Each is held as up to 48 words of 32 bits, so an operand can be 1536 bits wide, with the least significant word at word index 0. A host reads and writes any word through one word-addressed port. The arithmetic datapath has its own read port and its own write port. The datapath writes results into one of the four working operands, chosen by a 2-bit destination select.

A 2-bit pipeline-select input sets which words of every operand are in use:
- The full width uses all 48 words.
- The lower slice uses words 0 to 15.
- The upper slice uses words 16 to 47.
- The idle code uses no words.

Host accesses to words outside the active slice have no effect, and those words read back as zero. A collision flag tells the host when one of its accesses landed on the same operand that the datapath was touching in that cycle.

Top module: `opmem_ctrl`

## Requirements
- R1: The host address is 9 bits. Bits [8:6] pick the operand: codes 0 to 3 are working operands 0 to 3, and code 4 is the modulus. Bits [5:0] give the word index. Codes 5 to 7 are ignored on writes and read back zero.
- R2: With pipeline select 2'b11, words 0 to 47 are writable and read back their stored value. Words 48 to 63 ignore writes and read zero.
- R3: With pipeline select 2'b01, only words 0 to 15 are active. Any other word reads zero and ignores writes. A word hidden this way keeps its stored value for later modes.
- R4: With pipeline select 2'b10, only words 16 to 47 are active, so the lowest word of an operand sits at index 16. Words 0 to 15 read zero and ignore writes.
- R5: With pipeline select 2'b00, no word is active. All host reads return zero and host writes are ignored.
- R6: Host read data appears on host_rdata_o two rising clock edges after the address is presented. After only one edge, the output still shows the previous result.
- R7: A datapath write goes into working operand dp_dest_i at word dp_wword_i on the clock edge. Datapath read data appears one edge after dp_re_i. Datapath accesses are not restricted by the pipeline select.
- R8: collision_o is high for the cycle after an edge at which a host access (read or write) and a datapath access (read of dp_rop_i, or write into dp_dest_i) named the same operand code. Otherwise collision_o is low.
- R9: A host write made in a cycle that collides is discarded. The datapath write of that cycle still takes effect.
- R10: After reset, collision_o and both read outputs are zero, and every stored word is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pipe_sel_i | input | 2 | Active slice: 11 full, 01 lower, 10 upper, 00 none |
| host_addr_i | input | 9 | Operand code [8:6], word index [5:0] |
| host_we_i | input | 1 | Host write strobe |
| host_re_i | input | 1 | Host read strobe (used for collision reporting) |
| host_wdata_i | input | 32 | Host write data |
| host_rdata_o | output | 32 | Host read data, two-cycle latency |
| collision_o | output | 1 | Host and datapath touched the same operand last cycle |
| dp_re_i | input | 1 | Datapath read strobe |
| dp_rop_i | input | 3 | Datapath read operand code |
| dp_rword_i | input | 6 | Datapath read word index |
| dp_rdata_o | output | 32 | Datapath read data, one-cycle latency |
| dp_we_i | input | 1 | Datapath write strobe |
| dp_dest_i | input | 2 | Destination working operand |
| dp_wword_i | input | 6 | Datapath write word index |
| dp_wdata_i | input | 32 | Datapath write data |

## Verification
The hardest case to reach is a host write and a datapath write that name the same operand in the same cycle. To show the host write was dropped, the two strobes must line up on one edge, and the two writes must go to different words of that operand. The stimulus does exactly that on a single falling edge. It then checks the flag for one cycle and reads back both words. A second host write alongside a datapath write to another operand shows that both writes land when there is no clash. Hidden-word retention is shown by writing in full mode, reading zero through a narrower slice, and then reading the value again in full mode.

// File: rtl/opmem_pkg.sv
package opmem_pkg;
  localparam int WORD_W     = 32;
  localparam int OP_BITS    = 3;
  localparam int WORD_BITS  = 6;
  localparam int N_OPS      = 5;
  localparam int FULL_WORDS = 48;
  localparam int LOW_WORDS  = 16;

  typedef enum logic [1:0] {
    PSEL_OFF  = 2'b00,
    PSEL_LOW  = 2'b01,
    PSEL_HIGH = 2'b10,
    PSEL_FULL = 2'b11
  } psel_e;
endpackage

// File: rtl/opmem_decode.sv
module opmem_decode
  import opmem_pkg::*;
#(
  parameter int OPB   = OP_BITS,
  parameter int WB    = WORD_BITS,
  parameter int NOPS  = N_OPS,
  parameter int FULLW = FULL_WORDS,
  parameter int LOWW  = LOW_WORDS
) (
  input  logic [OPB+WB-1:0] addr_i,
  input  logic [1:0]        psel_i,
  output logic [OPB-1:0]    op_o,
  output logic [WB-1:0]     word_o,
  output logic              ok_o
);
  localparam logic [WB-1:0]  FULL_L = WB'(FULLW);
  localparam logic [WB-1:0]  LOW_L  = WB'(LOWW);
  localparam logic [OPB-1:0] NOPS_L = OPB'(NOPS);

  logic act;

  assign op_o   = addr_i[OPB+WB-1:WB];
  assign word_o = addr_i[WB-1:0];

  always_comb begin
    unique case (psel_e'(psel_i))
      PSEL_FULL: act = word_o < FULL_L;
      PSEL_LOW:  act = word_o < LOW_L;
      PSEL_HIGH: act = (word_o >= LOW_L) && (word_o < FULL_L);
      default:   act = 1'b0;
    endcase
  end

  assign ok_o = act && (op_o < NOPS_L);
endmodule

// File: rtl/opmem_collide.sv
module opmem_collide #(
  parameter int OPB  = 3,
  parameter int NOPS = 5
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           host_acc_i,
  input  logic [OPB-1:0] host_op_i,
  input  logic           dp_re_i,
  input  logic [OPB-1:0] dp_rop_i,
  input  logic           dp_we_i,
  input  logic [OPB-1:0] dp_wop_i,
  output logic           clash_o,
  output logic           collision_o
);
  localparam logic [OPB-1:0] NOPS_L = OPB'(NOPS);

  logic dp_hit;
  assign dp_hit  = (dp_re_i && dp_rop_i == host_op_i) ||
                   (dp_we_i && dp_wop_i == host_op_i);
  assign clash_o = host_acc_i && (host_op_i < NOPS_L) && dp_hit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) collision_o <= 1'b0;
    else         collision_o <= clash_o;
  end

  // flag only follows a cycle with some datapath activity
  p_flag_needs_dp_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    collision_o |-> $past(dp_re_i || dp_we_i));
endmodule

// File: rtl/opmem_bank.sv
module opmem_bank #(
  parameter int W     = 32,
  parameter int OPB   = 3,
  parameter int WB    = 6,
  parameter int NOPS  = 5,
  parameter int DEPTH = 48
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           h_we_i,
  input  logic [OPB-1:0] h_wop_i,
  input  logic [WB-1:0]  h_wword_i,
  input  logic [W-1:0]   h_wdata_i,
  input  logic [OPB-1:0] h_rop_i,
  input  logic [WB-1:0]  h_rword_i,
  output logic [W-1:0]   h_rdata_o,
  input  logic           d_we_i,
  input  logic [OPB-1:0] d_wop_i,
  input  logic [WB-1:0]  d_wword_i,
  input  logic [W-1:0]   d_wdata_i,
  input  logic [OPB-1:0] d_rop_i,
  input  logic [WB-1:0]  d_rword_i,
  output logic [W-1:0]   d_rdata_o
);
  localparam logic [WB-1:0]  DEPTH_L = WB'(DEPTH);
  localparam logic [OPB-1:0] NOPS_L  = OPB'(NOPS);

  logic [W-1:0] h_pick [NOPS];
  logic [W-1:0] d_pick [NOPS];
  logic         d_we_ok;

  assign d_we_ok = d_we_i && (d_wword_i < DEPTH_L);

  for (genvar g = 0; g < NOPS; g++) begin : g_op
    logic [W-1:0] words_q [DEPTH];

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        for (int i = 0; i < DEPTH; i++) words_q[i] <= '0;
      end else begin
        if (h_we_i && h_wop_i == OPB'(g)) words_q[h_wword_i] <= h_wdata_i;
        if (d_we_ok && d_wop_i == OPB'(g)) words_q[d_wword_i] <= d_wdata_i;
      end
    end

    assign h_pick[g] = (h_rword_i < DEPTH_L) ? words_q[h_rword_i] : '0;
    assign d_pick[g] = (d_rword_i < DEPTH_L) ? words_q[d_rword_i] : '0;

    p_host_write_lands_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (h_we_i && h_wop_i == OPB'(g)) |=> words_q[$past(h_wword_i)] == $past(h_wdata_i));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      h_rdata_o <= '0;
      d_rdata_o <= '0;
    end else begin
      h_rdata_o <= (h_rop_i < NOPS_L) ? h_pick[h_rop_i] : '0;
      d_rdata_o <= (d_rop_i < NOPS_L) ? d_pick[d_rop_i] : '0;
    end
  end

  // a host write reaching storage never shares an operand with a datapath write
  p_no_shared_write_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(h_we_i && d_we_i && h_wop_i == d_wop_i));
endmodule

// File: rtl/opmem_ctrl.sv
module opmem_ctrl
  import opmem_pkg::*;
#(
  parameter int W     = WORD_W,
  parameter int OPB   = OP_BITS,
  parameter int WB    = WORD_BITS,
  parameter int NOPS  = N_OPS,
  parameter int FULLW = FULL_WORDS,
  parameter int LOWW  = LOW_WORDS
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [1:0]        pipe_sel_i,
  input  logic [OPB+WB-1:0] host_addr_i,
  input  logic              host_we_i,
  input  logic              host_re_i,
  input  logic [W-1:0]      host_wdata_i,
  output logic [W-1:0]      host_rdata_o,
  output logic              collision_o,
  input  logic              dp_re_i,
  input  logic [OPB-1:0]    dp_rop_i,
  input  logic [WB-1:0]     dp_rword_i,
  output logic [W-1:0]      dp_rdata_o,
  input  logic              dp_we_i,
  input  logic [OPB-2:0]    dp_dest_i,
  input  logic [WB-1:0]     dp_wword_i,
  input  logic [W-1:0]      dp_wdata_i
);
  logic [OPB-1:0] h_op;
  logic [WB-1:0]  h_word;
  logic           h_ok, ok_q, clash, h_we_eff;
  logic [OPB-1:0] dp_wop;
  logic [W-1:0]   raw_q;

  assign dp_wop = {1'b0, dp_dest_i};

  opmem_decode #(.OPB(OPB), .WB(WB), .NOPS(NOPS), .FULLW(FULLW), .LOWW(LOWW)) u_dec (
    .addr_i(host_addr_i), .psel_i(pipe_sel_i),
    .op_o(h_op), .word_o(h_word), .ok_o(h_ok)
  );

  opmem_collide #(.OPB(OPB), .NOPS(NOPS)) u_col (
    .clk_i, .rst_ni,
    .host_acc_i(host_we_i || host_re_i), .host_op_i(h_op),
    .dp_re_i, .dp_rop_i, .dp_we_i, .dp_wop_i(dp_wop),
    .clash_o(clash), .collision_o
  );

  assign h_we_eff = host_we_i && h_ok && !clash;

  opmem_bank #(.W(W), .OPB(OPB), .WB(WB), .NOPS(NOPS), .DEPTH(FULLW)) u_bank (
    .clk_i, .rst_ni,
    .h_we_i(h_we_eff), .h_wop_i(h_op), .h_wword_i(h_word), .h_wdata_i(host_wdata_i),
    .h_rop_i(h_op), .h_rword_i(h_word), .h_rdata_o(raw_q),
    .d_we_i(dp_we_i), .d_wop_i(dp_wop), .d_wword_i(dp_wword_i), .d_wdata_i(dp_wdata_i),
    .d_rop_i(dp_rop_i), .d_rword_i(dp_rword_i), .d_rdata_o(dp_rdata_o)
  );

  // second read stage masks words outside the active slice
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ok_q         <= 1'b0;
      host_rdata_o <= '0;
    end else begin
      ok_q         <= h_ok;
      host_rdata_o <= ok_q ? raw_q : '0;
    end
  end

  p_bad_op_reads_zero_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (host_addr_i[OPB+WB-1:WB] >= OPB'(NOPS)) |=> ##1 (host_rdata_o == '0));

  p_idle_reads_zero_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pipe_sel_i == 2'b00) |=> ##1 (host_rdata_o == '0));

  p_flag_needs_host_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    collision_o |-> $past(host_we_i || host_re_i));
endmodule

// File: tb/tb_opmem_ctrl.sv
module tb_opmem_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  psel = 2'b11;
  logic [8:0]  addr = '0;
  logic        hwe = 1'b0, hre = 1'b0;
  logic [31:0] hwd = '0;
  logic [31:0] hrd;
  logic        coll;
  logic        dre = 1'b0, dwe = 1'b0;
  logic [2:0]  drop = '0;
  logic [5:0]  drw = '0, dww = '0;
  logic [1:0]  ddest = '0;
  logic [31:0] dwd = '0;
  logic [31:0] drd;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  opmem_ctrl dut (
    .clk_i(clk), .rst_ni(rst_n), .pipe_sel_i(psel),
    .host_addr_i(addr), .host_we_i(hwe), .host_re_i(hre),
    .host_wdata_i(hwd), .host_rdata_o(hrd), .collision_o(coll),
    .dp_re_i(dre), .dp_rop_i(drop), .dp_rword_i(drw), .dp_rdata_o(drd),
    .dp_we_i(dwe), .dp_dest_i(ddest), .dp_wword_i(dww), .dp_wdata_i(dwd)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic hw(input logic [2:0] op, input logic [5:0] w, input logic [31:0] d);
    @(negedge clk);
    addr = {op, w}; hwd = d; hwe = 1'b1;
    @(negedge clk);
    hwe = 1'b0;
  endtask

  task automatic hr(input string tag, input logic [2:0] op, input logic [5:0] w,
                    input logic [31:0] exp);
    @(negedge clk);
    addr = {op, w}; hre = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    hre = 1'b0;
    chk(tag, hrd, exp);
  endtask

  task automatic t_reset;
    hr("R10 reset word", 3'd0, 6'd0, 32'h0);
    chk("R10 reset collision", {31'b0, coll}, 32'h0);
    chk("R10 reset dp read", drd, 32'h0);
  endtask

  task automatic t_full;
    psel = 2'b11;
    hw(3'd0, 6'd0, 32'hA000_0001);
    hw(3'd4, 6'd47, 32'hB000_0047);
    hw(3'd3, 6'd20, 32'hC000_0020);
    hr("R2 op0 w0", 3'd0, 6'd0, 32'hA000_0001);
    hr("R1 modulus w47", 3'd4, 6'd47, 32'hB000_0047);
    hr("R2 op3 w20", 3'd3, 6'd20, 32'hC000_0020);
    hw(3'd0, 6'd50, 32'hDEAD_0050);
    hr("R2 word 50 zero", 3'd0, 6'd50, 32'h0);
    hw(3'd5, 6'd1, 32'hDEAD_0501);
    hr("R1 code5 zero", 3'd5, 6'd1, 32'h0);
    hr("R1 code5 write no alias", 3'd1, 6'd1, 32'h0);
    hr("R1 op0 w0 intact", 3'd0, 6'd0, 32'hA000_0001);
    // latency: switch address, value must hold for one edge
    @(negedge clk);
    addr = {3'd4, 6'd47};
    @(posedge clk); @(negedge clk);
    chk("R6 one edge old data", hrd, 32'hA000_0001);
    @(posedge clk); @(negedge clk);
    chk("R6 two edges new data", hrd, 32'hB000_0047);
  endtask

  task automatic t_lower;
    psel = 2'b01;
    hw(3'd1, 6'd5, 32'h1111_0005);
    hr("R3 lower w5", 3'd1, 6'd5, 32'h1111_0005);
    hr("R3 hidden w20 zero", 3'd3, 6'd20, 32'h0);
    hw(3'd1, 6'd16, 32'hDEAD_0116);
    psel = 2'b11;
    hr("R3 w16 write ignored", 3'd1, 6'd16, 32'h0);
    hr("R3 hidden w20 kept", 3'd3, 6'd20, 32'hC000_0020);
  endtask

  task automatic t_upper;
    psel = 2'b10;
    hr("R4 upper w20", 3'd3, 6'd20, 32'hC000_0020);
    hr("R4 w0 zero", 3'd0, 6'd0, 32'h0);
    hw(3'd2, 6'd10, 32'hDEAD_0210);
    hw(3'd2, 6'd16, 32'h2222_0016);
    hr("R4 first word at 16", 3'd2, 6'd16, 32'h2222_0016);
    psel = 2'b11;
    hr("R4 w10 write ignored", 3'd2, 6'd10, 32'h0);
  endtask

  task automatic t_off;
    psel = 2'b00;
    hr("R5 idle read zero", 3'd0, 6'd0, 32'h0);
    hw(3'd0, 6'd1, 32'hDEAD_0001);
    psel = 2'b11;
    hr("R5 idle write ignored", 3'd0, 6'd1, 32'h0);
  endtask

  task automatic t_dp;
    psel = 2'b01;
    @(negedge clk);
    dwe = 1'b1; ddest = 2'd2; dww = 6'd40; dwd = 32'h3333_0040;
    @(negedge clk);
    dwe = 1'b0; dre = 1'b1; drop = 3'd3; drw = 6'd20;
    @(negedge clk);
    dre = 1'b0;
    chk("R7 dp read outside slice", drd, 32'hC000_0020);
    @(negedge clk);
    dre = 1'b1; drop = 3'd2; drw = 6'd40;
    @(negedge clk);
    dre = 1'b0;
    chk("R7 dp write landed", drd, 32'h3333_0040);
    psel = 2'b11;
    hr("R7 host sees dp write", 3'd2, 6'd40, 32'h3333_0040);
  endtask

  task automatic t_collide;
    psel = 2'b11;
    @(negedge clk);
    addr = {3'd1, 6'd7}; hwd = 32'hEEEE_0007; hwe = 1'b1;
    dwe = 1'b1; ddest = 2'd1; dww = 6'd8; dwd = 32'hFFFF_0008;
    @(negedge clk);
    hwe = 1'b0; dwe = 1'b0;
    chk("R8 collision raised", {31'b0, coll}, 32'h1);
    @(negedge clk);
    chk("R8 collision drops", {31'b0, coll}, 32'h0);
    hr("R9 host write discarded", 3'd1, 6'd7, 32'h0);
    hr("R9 dp write kept", 3'd1, 6'd8, 32'hFFFF_0008);
    // read clash on modulus
    @(negedge clk);
    addr = {3'd4, 6'd0}; hre = 1'b1; dre = 1'b1; drop = 3'd4; drw = 6'd0;
    @(negedge clk);
    hre = 1'b0; dre = 1'b0;
    chk("R8 read clash flagged", {31'b0, coll}, 32'h1);
    // different operands: no flag, both land
    @(negedge clk);
    addr = {3'd0, 6'd9}; hwd = 32'h4444_0009; hwe = 1'b1;
    dwe = 1'b1; ddest = 2'd1; dww = 6'd9; dwd = 32'h5555_0009;
    @(negedge clk);
    hwe = 1'b0; dwe = 1'b0;
    chk("R8 no flag different op", {31'b0, coll}, 32'h0);
    hr("R9 host write op0 kept", 3'd0, 6'd9, 32'h4444_0009);
    hr("R9 dp write op1 kept", 3'd1, 6'd9, 32'h5555_0009);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_full();
    t_lower();
    t_upper();
    t_off();
    t_dp();
    t_collide();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule